// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block performs a single read from an SDRAM row that is already open and stops the burst once a requested number of words has arrived. The stopping command is either a bank PRECHARGE or a BURST TERMINATE, chosen per request. The block places that command so that the data bus goes quiet immediately after the last wanted word. When a precharge is used, the block also keeps the bank marked busy until the row precharge time has passed.

A request carries the bank, the column, the word count, the stopping method, an auto-precharge flag, a burst-type flag (full page or fixed length) and the CAS latency (2 or 3). The block accepts a request only while its ready flag is high. Requests that cannot legally be cut short are refused with a one-cycle error pulse. While the words are on the bus, a data-valid strobe marks each wanted word.

Top module: `sdram_rd_trunc`

## Requirements
- R1: With latency L (L = 3 when `req_cas3` is 1, else 2) and count N, `rd_valid` is high exactly in cycles L .. L+N-1, counted from the READ cycle (cycle 0), and low in every other cycle.
- R2: The READ command is driven as {cs_n,ras_n,cas_n,we_n} = 4'b0101 in the cycle after the request is accepted. In that cycle `ba` equals the requested bank, `addr[COL_W-1:0]` equals the column, and `addr[AP_BIT]` equals the auto-precharge flag.
- R3: When `req_use_bst` is 0, a PRECHARGE (4'b0010) is issued in cycle N, which is L-1 cycles before the cycle holding the last wanted word. It goes to the same bank, with `addr[AP_BIT]` low.
- R4: When `req_use_bst` is 1, a BURST TERMINATE (4'b0110) is issued in cycle N, with the same lead as in R3.
- R5: A request is refused in any of three cases: N is 0; the burst is fixed length (`req_full_page` = 0) with auto precharge; or the burst is fixed length with N greater than BURST_LEN. A refused request raises `req_err` for exactly one cycle, issues no command and leaves `bank_ready` high. Full-page requests with N ≥ 1 are always accepted.
- R6: `bank_ready` is low from the READ cycle through cycle L+N-1. After a PRECHARGE in cycle N, it also stays low for TRP cycles, counting the PRECHARGE cycle itself.
- R7: NOP (4'b0111) is driven in every cycle that carries no READ, PRECHARGE or BURST TERMINATE. `dqm` is low at all times.
- R8: A request is taken only when `bank_ready` is high. A request presented while it is low produces no command and no error.
- R9: A fixed burst of four words that is stopped by PRECHARGE gives four valid words in cycles L .. L+3, with the PRECHARGE in cycle 4. This is the same data sequence as a burst of four with auto precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Start column |
| req_words | input | CNT_W | Number of words wanted |
| req_use_bst | input | 1 | 1 = stop with BURST TERMINATE, 0 = stop with PRECHARGE |
| req_auto_pre | input | 1 | Auto-precharge flag carried by the READ |
| req_full_page | input | 1 | 1 = full-page burst, 0 = fixed-length burst |
| req_cas3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines |
| ba | output | BA_W | Bank lines |
| dqm | output | 1 | Data mask, held low |
| rd_valid | output | 1 | Marks a wanted read word on the bus |
| bank_ready | output | 1 | Bank free for a new request |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The stopping command and the data stream share cycles. Whenever N ≥ L, the PRECHARGE or BURST TERMINATE lands in a cycle where `rd_valid` is still high. With latency 3 and short bursts, the precharge hold window overlaps the tail of the data. The bench sweeps both latencies, both stopping methods, both burst types and word counts on both sides of the latency. It predicts each cycle's command, strobe and ready level arithmetically. Throughout each busy window it also holds a competing request, to show that overlap never lets a second READ in.

// File: rtl/sdram_rd_pkg.sv
`timescale 1ns/1ps
package sdram_rd_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = sd_cmd_t'(4'b0111);
  localparam sd_cmd_t CMD_RD  = sd_cmd_t'(4'b0101);
  localparam sd_cmd_t CMD_PRE = sd_cmd_t'(4'b0010);
  localparam sd_cmd_t CMD_BST = sd_cmd_t'(4'b0110);

  // CAS latency in cycles from the select bit
  function automatic logic [2:0] lat_cycles(input logic cas3);
    return cas3 ? 3'd3 : 3'd2;
  endfunction

  // a burst may be cut short unless it is fixed length with auto precharge
  function automatic logic req_legal(input int words, input int blen,
                                     input logic full, input logic ap);
    return (words != 0) && (full || (!ap && (words <= blen)));
  endfunction
endpackage

// File: rtl/rd_beat_ctr.sv
`timescale 1ns/1ps
module rd_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] words,
  input  logic [2:0]       lat,
  output logic             busy,
  output logic             rd_valid,
  output logic             trunc_due
);
  localparam int CYC_W = CNT_W + 2;

  logic [CYC_W-1:0] cyc_q;
  logic [CNT_W-1:0] words_q;
  logic [2:0]       lat_q;
  logic             busy_q;
  logic [CYC_W-1:0] last_cyc;

  // cycle index of the final wanted word, READ cycle = 0
  assign last_cyc = CYC_W'(lat_q) + CYC_W'(words_q) - CYC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cyc_q   <= '0;
      words_q <= '0;
      lat_q   <= 3'd2;
    end else if (start) begin
      busy_q  <= 1'b1;
      cyc_q   <= '0;
      words_q <= words;
      lat_q   <= lat;
    end else if (busy_q) begin
      if (cyc_q == last_cyc) busy_q <= 1'b0;
      else                   cyc_q  <= cyc_q + CYC_W'(1);
    end
  end

  assign busy      = busy_q;
  assign rd_valid  = busy_q && (cyc_q >= CYC_W'(lat_q)) && (cyc_q <= last_cyc);
  // next cycle is cycle N: L-1 ahead of the last word at L+N-1
  assign trunc_due = busy_q && ((cyc_q + CYC_W'(1)) == CYC_W'(words_q));

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R1
  valid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cyc_q == last_cyc && !start) |=> !rd_valid);
endmodule

// File: rtl/trp_guard.sv
`timescale 1ns/1ps
module trp_guard #(
  parameter int TRP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic hold
);
  localparam int CW = $clog2(TRP + 1);

  logic [CW-1:0] cnt_q;

  // counter reads TRP in the PRECHARGE cycle and reaches 0 TRP cycles later
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= CW'(TRP);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign hold = (cnt_q != '0);

  // R6
  trp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold);
endmodule

// File: rtl/sdram_rd_trunc.sv
`timescale 1ns/1ps
module sdram_rd_trunc
  import sdram_rd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int CNT_W     = 4,
  parameter int BURST_LEN = 4,
  parameter int TRP       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [CNT_W-1:0]  req_words,
  input  logic              req_use_bst,
  input  logic              req_auto_pre,
  input  logic              req_full_page,
  input  logic              req_cas3,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              dqm,
  output logic              rd_valid,
  output logic              bank_ready,
  output logic              req_err
);
  // named events for checking
  logic accept, legal, start, reject;
  logic busy, trunc_due, pre_load, trp_hold;
  logic [2:0] lat;
  logic [ADDR_W-1:0] rd_addr;

  sd_cmd_t          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic              bst_q;
  logic              err_q;

  assign lat    = lat_cycles(req_cas3);
  assign legal  = req_legal(int'(req_words), BURST_LEN, req_full_page, req_auto_pre);
  assign accept = req_valid && bank_ready;
  assign start  = accept && legal;
  assign reject = accept && !legal;

  always_comb begin
    rd_addr                = '0;
    rd_addr[COL_W-1:0]     = req_col;
    rd_addr[AP_BIT]        = req_auto_pre;
  end

  rd_beat_ctr #(.CNT_W(CNT_W)) beat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .words     (req_words),
    .lat       (lat),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .trunc_due (trunc_due)
  );

  assign pre_load = trunc_due && !bst_q;

  trp_guard #(.TRP(TRP)) trp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pre_load),
    .hold  (trp_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      bst_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject;
      if (start) begin
        cmd_q  <= CMD_RD;
        addr_q <= rd_addr;
        ba_q   <= req_bank;
        bst_q  <= req_use_bst;
      end else if (trunc_due) begin
        cmd_q  <= bst_q ? CMD_BST : CMD_PRE;
        addr_q <= '0;
      end else begin
        cmd_q  <= CMD_NOP;
      end
    end
  end

  assign bank_ready = !busy && !trp_hold;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr    = addr_q;
  assign ba      = ba_q;
  assign dqm     = 1'b0;
  assign req_err = err_q;

  logic is_rd, is_pre, is_bst, is_nop;
  assign is_rd  = (cmd_q == CMD_RD);
  assign is_pre = (cmd_q == CMD_PRE);
  assign is_bst = (cmd_q == CMD_BST);
  assign is_nop = (cmd_q == CMD_NOP);

  // R2
  read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> ($past(req_valid) && !bank_ready));

  // R3
  pre_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> !addr[AP_BIT]);

  // R6
  pre_blocks_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !bank_ready);

  // R1
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !bank_ready);

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (is_nop && bank_ready));

  // R7
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({is_rd, is_pre, is_bst, is_nop}) == 1);
endmodule

// File: tb/sdram_rd_trunc_tb.sv
`timescale 1ns/1ps
module sdram_rd_trunc_tb_top;
  localparam int BA_W = 2, COL_W = 8, ADDR_W = 12, AP_BIT = 10;
  localparam int CNT_W = 4, BLEN = 4, TRP = 3;
  localparam logic [3:0] E_NOP = 4'b0111, E_RD = 4'b0101,
                         E_PRE = 4'b0010, E_BST = 4'b0110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [CNT_W-1:0] req_words = '0;
  logic req_use_bst = 1'b0, req_auto_pre = 1'b0, req_full_page = 1'b0, req_cas3 = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, dqm, rd_valid, bank_ready, req_err;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_rd_trunc #(.BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
                   .CNT_W(CNT_W), .BURST_LEN(BLEN), .TRP(TRP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .req_words(req_words), .req_use_bst(req_use_bst),
    .req_auto_pre(req_auto_pre), .req_full_page(req_full_page), .req_cas3(req_cas3),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .dqm(dqm), .rd_valid(rd_valid), .bank_ready(bank_ready), .req_err(req_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic run_case(input int cl, input int n, input bit full, input bit ap,
                          input bit bst, input int bank, input int col);
    bit legal;
    logic [3:0] ecmd;
    string tag;
    bit erdy, ev;
    legal = (n != 0) && (full || (!ap && n <= BLEN));
    while (!bank_ready) @(negedge clk);
    req_valid = 1'b1; req_bank = BA_W'(bank); req_col = COL_W'(col);
    req_words = CNT_W'(n); req_full_page = full; req_auto_pre = ap;
    req_use_bst = bst; req_cas3 = (cl == 3);
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      // R5 refused request: error pulse, no command, ready stays high
      chk(req_err === 1'b1, "R5 err", int'(req_err), 1);
      chk(cmd_now() === E_NOP, "R5 cmd", int'(cmd_now()), int'(E_NOP));
      chk(bank_ready === 1'b1, "R5 ready", int'(bank_ready), 1);
      @(negedge clk);
      chk(req_err === 1'b0, "R5 pulse", int'(req_err), 0);
      chk(cmd_now() === E_NOP, "R5 cmd2", int'(cmd_now()), int'(E_NOP));
      return;
    end
    for (int k = 0; k <= cl + n + TRP + 1; k++) begin
      if (k == 0) begin
        ecmd = E_RD; tag = "R2";
      end else if (k == n) begin
        ecmd = bst ? E_BST : E_PRE;
        tag = bst ? "R4" : ((!full && n == 4) ? "R9" : "R3");
      end else begin
        ecmd = E_NOP; tag = (k < cl + n) ? "R8" : "R7";
      end
      chk(cmd_now() === ecmd, tag, int'(cmd_now()), int'(ecmd));
      if (k == 0) begin
        chk(ba === BA_W'(bank), "R2 bank", int'(ba), bank);
        chk(addr[COL_W-1:0] === COL_W'(col), "R2 col", int'(addr[COL_W-1:0]), col);
        chk(addr[AP_BIT] === ap, "R2 ap", int'(addr[AP_BIT]), int'(ap));
      end
      if (k == n && !bst) begin
        chk(addr[AP_BIT] === 1'b0, "R3 a10", int'(addr[AP_BIT]), 0);
        chk(ba === BA_W'(bank), "R3 bank", int'(ba), bank);
      end
      ev = (k >= cl) && (k < cl + n);
      chk(rd_valid === ev, (!full && n == 4 && !bst) ? "R9 valid" : "R1 valid",
          int'(rd_valid), int'(ev));
      erdy = (k >= cl + n) && !(!bst && k >= n && k < n + TRP);
      chk(bank_ready === erdy, "R6 ready", int'(bank_ready), int'(erdy));
      chk(dqm === 1'b0, "R7 dqm", int'(dqm), 0);
      chk(req_err === 1'b0, "R8 err", int'(req_err), 0);
      // R8 competing request held while the bank is busy
      if (k < cl + n) begin
        req_valid = 1'b1; req_bank = BA_W'(~bank); req_words = CNT_W'(1);
        req_full_page = 1'b1; req_auto_pre = 1'b0;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(cmd_now() === E_NOP, "R7 reset cmd", int'(cmd_now()), int'(E_NOP));
    chk(rd_valid === 1'b0, "R1 reset valid", int'(rd_valid), 0);
    chk(dqm === 1'b0, "R7 reset dqm", int'(dqm), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bank_ready === 1'b1, "R6 reset ready", int'(bank_ready), 1);
    chk(req_err === 1'b0, "R5 reset err", int'(req_err), 0);
    for (int cl = 2; cl <= 3; cl++) begin
      for (int full = 0; full <= 1; full++) begin
        for (int n = 0; n <= (full ? 9 : 5); n++) begin
          for (int ap = 0; ap <= 1; ap++) begin
            for (int bst = 0; bst <= 1; bst++) begin
              run_case(cl, n, full[0], ap[0], bst[0], (n + bst) % 4, (n * 37 + cl * 5 + ap) % 256);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule